// File: doc/BRIEF.md
# Manchester Receive Decoder with Carrier Sense

This block turns an oversampled Manchester bit stream into NRZ data, a recovered bit clock and a carrier-sense flag. A single sample clock runs at `OVS` times the bit rate. A low-going pulse on the selected input starts a frame, but only once it lasts `MIN_PULSE` samples. From then on, one counter measures the time since the last accepted mid-cell transition. That counter re-centres on each transition inside a window around the expected position. The recovered clock phase and the data sampling point both come from the same counter.

When the mid-cell transitions stop, carrier sense drops one and a half bit times after the last one. The recovered clock then keeps running for `TAIL_BITS` further cycles and is held low after that. A loopback select takes the local transmit stream in place of the line input, so a controller can check its own encoder without line activity.

Frames must open with a 0 cell. A 0 cell is high then low, so its first half equals the idle level. This makes the first falling transition a mid-cell one. A 1 cell is low then high. The decoded bit is the level in the second half of the cell.

Top module: `rxdec_top`

## Requirements
- R1: After reset, `carrier`, `rx_clk` and `rx_data` are all 0.
- R2: A low run on the selected input shorter than `MIN_PULSE` samples never raises `carrier`.
- R3: A low run that reaches `MIN_PULSE` samples raises `carrier` exactly `IN_STAGES + MIN_PULSE` sample clocks after the first low sample was presented.
- R4: The first falling transition of a frame is treated as a mid-cell transition. This means frames start with a 0 cell (high then low).
- R5: `rx_data` takes the line level `OVS/4` samples after each accepted mid-cell transition. `rx_clk` rises `OVS/2` samples after it, and `rx_data` is stable at every rising edge of `rx_clk`. Every cell after the first is delivered at its own rising edge.
- R6: A transition is accepted as mid-cell only when it lies within `±OVS/4` samples of the expected point. Cell-boundary transitions are ignored. Mid-cell transitions displaced by up to one sample still decode correctly.
- R7: `carrier` falls `OVS + OVS/2 + IN_STAGES` sample clocks after the last mid-cell transition is presented.
- R8: After `carrier` falls, `rx_clk` gives exactly `TAIL_BITS` rising edges (the first one coincides with the fall). After that it stays low until the next frame is qualified.
- R9: Input activity during the clock tail does not start a new frame.
- R10: With `loop_sel` high, the decoder uses `loop_tx`, and any activity on `line_rx` has no effect on the outputs.
- R11: When no frame is in progress and the tail has ended, `rx_clk` and `carrier` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, `OVS` times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_sel | input | 1 | 1 selects the local loopback stream |
| line_rx | input | 1 | Manchester stream from the line, idle high |
| loop_tx | input | 1 | Locally encoded Manchester stream, idle high |
| carrier | output | 1 | Carrier sense |
| rx_data | output | 1 | Recovered NRZ data |
| rx_clk | output | 1 | Recovered bit clock |

## Verification
A behavioural model runs in the bench and is advanced on each sample clock. Its three outputs are compared with the design's outputs in the middle of every clock period.

On top of that model, event-based checks confirm the timing rules on their own terms:
- Carrier rises `IN_STAGES + MIN_PULSE` clocks after the first qualifying low sample is driven.
- Carrier falls `OVS + OVS/2 + IN_STAGES` clocks after the final mid-cell transition is driven.
- Exactly `TAIL_BITS` clock rises follow the fall.
- The bits captured at `rx_clk` rising edges match the transmitted cells.

Each of these timing checks counts sample clocks from the cycle in which the bench drove the stimulus.

// File: rtl/rxdec_pkg.sv
package rxdec_pkg;
   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_RUN  = 2'd1,
      RX_TAIL = 2'd2
   } rx_state_e;
endpackage

// File: rtl/rxdec_insel.sv
module rxdec_insel #(
   parameter int IN_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic loop_sel,
   input  logic line_rx,
   input  logic loop_tx,
   output logic smp_o,
   output logic smp_d_o
);
   logic                 pick;
   logic [IN_STAGES-1:0] pipe;

   assign pick = loop_sel ? loop_tx : line_rx;

   generate
      if (IN_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe <= '1;
            else        pipe <= pick;
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[IN_STAGES-2:0], pick};
      end
   endgenerate

   assign smp_o = pipe[IN_STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) smp_d_o <= 1'b1;
      else        smp_d_o <= smp_o;
endmodule

// File: rtl/rxdec_squelch.sv
module rxdec_squelch #(
   parameter int MIN_PULSE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_i,
   input  logic armed_i,
   output logic qual_o
);
   localparam int LW = $clog2(MIN_PULSE + 1);
   localparam logic [LW-1:0] L_SAT = LW'(MIN_PULSE);
   localparam logic [LW-1:0] L_HIT = LW'(MIN_PULSE - 1);

   logic [LW-1:0] lowcnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)              lowcnt <= '0;
      else if (smp_i)          lowcnt <= '0;
      else if (lowcnt != L_SAT) lowcnt <= lowcnt + LW'(1);

   assign qual_o = armed_i && !smp_i && (lowcnt == L_HIT);

   // R2: a qualifying sample always follows at least one earlier low sample
   assert_qual_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      qual_o |-> (!smp_i && $past(!smp_i)));
endmodule

// File: rtl/rxdec_track.sv
module rxdec_track
   import rxdec_pkg::*;
#(
   parameter int OVS       = 8,
   parameter int MIN_PULSE = 3,
   parameter int TAIL_BITS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_i,
   input  logic smp_d_i,
   input  logic qual_i,
   output logic idle_o,
   output logic carrier_o,
   output logic rx_clk_o,
   output logic rx_data_o
);
   localparam int HALF = OVS / 2;
   localparam int WIN  = OVS / 4;
   localparam int DROP = OVS + HALF;
   localparam int LAST = DROP + TAIL_BITS * OVS - 1;
   localparam int CW   = $clog2(LAST + 1);
   localparam int PW   = $clog2(OVS);
   localparam logic [CW-1:0] C_START = CW'(MIN_PULSE);
   localparam logic [CW-1:0] C_ONE   = CW'(1);
   localparam logic [CW-1:0] C_SAMP  = CW'(WIN);
   localparam logic [CW-1:0] C_WLO   = CW'(OVS - WIN);
   localparam logic [CW-1:0] C_WHI   = CW'(OVS + WIN);
   localparam logic [CW-1:0] C_DROPM = CW'(DROP - 1);
   localparam logic [CW-1:0] C_LAST  = CW'(LAST);

   rx_state_e     st;
   logic [CW-1:0] cnt;
   logic          edge_seen;
   logic          in_win;

   assign edge_seen = smp_i ^ smp_d_i;
   assign in_win    = (cnt >= C_WLO) && (cnt <= C_WHI);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st        <= RX_IDLE;
         cnt       <= '0;
         rx_data_o <= 1'b0;
      end else begin
         case (st)
            RX_IDLE: if (qual_i) begin
               st  <= RX_RUN;
               cnt <= C_START;
            end
            RX_RUN: begin
               if (cnt == C_SAMP) rx_data_o <= smp_i;
               if (edge_seen && in_win) cnt <= C_ONE;
               else if (cnt == C_DROPM) begin
                  st  <= RX_TAIL;
                  cnt <= cnt + CW'(1);
               end else cnt <= cnt + CW'(1);
            end
            RX_TAIL: if (cnt == C_LAST) begin
               st  <= RX_IDLE;
               cnt <= '0;
            end else cnt <= cnt + CW'(1);
            default: st <= RX_IDLE;
         endcase
      end

   assign idle_o    = (st == RX_IDLE);
   assign carrier_o = (st == RX_RUN);
   assign rx_clk_o  = (st != RX_IDLE) && cnt[PW-1];

   // R5: data never changes on a rising recovered-clock edge
   assert_rxd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_clk_o) |-> $stable(rx_data_o));
   // R6: re-centring only happens on a seen transition
   assert_recentre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_RUN && $past(st) == RX_RUN && cnt == C_ONE) |-> $past(edge_seen));
   // R7: carrier falls only once the gap reached its limit
   assert_drop_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(carrier_o) |-> ($past(cnt) == C_DROPM));
   // R9: the tail never re-enters a frame directly
   assert_tail_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_TAIL) |=> (st != RX_RUN));
endmodule

// File: rtl/rxdec_top.sv
module rxdec_top #(
   parameter int OVS       = 8,
   parameter int MIN_PULSE = 3,
   parameter int TAIL_BITS = 5,
   parameter int IN_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic loop_sel,
   input  logic line_rx,
   input  logic loop_tx,
   output logic carrier,
   output logic rx_data,
   output logic rx_clk
);
   generate
      if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 8");
      end
      if (MIN_PULSE < 2 || MIN_PULSE > OVS / 2 - 1) begin : g_bad_pulse
         $error("MIN_PULSE must lie in 2 .. OVS/2-1");
      end
      if (TAIL_BITS < 1) begin : g_bad_tail
         $error("TAIL_BITS must be at least 1");
      end
      if (IN_STAGES < 1) begin : g_bad_stages
         $error("IN_STAGES must be at least 1");
      end
   endgenerate

   logic smp, smp_d, qual, idle;

   rxdec_insel #(.IN_STAGES(IN_STAGES)) u_insel (
      .clk(clk), .rst_n(rst_n), .loop_sel(loop_sel), .line_rx(line_rx),
      .loop_tx(loop_tx), .smp_o(smp), .smp_d_o(smp_d));

   rxdec_squelch #(.MIN_PULSE(MIN_PULSE)) u_sq (
      .clk(clk), .rst_n(rst_n), .smp_i(smp), .armed_i(idle), .qual_o(qual));

   rxdec_track #(.OVS(OVS), .MIN_PULSE(MIN_PULSE), .TAIL_BITS(TAIL_BITS)) u_trk (
      .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_d_i(smp_d), .qual_i(qual),
      .idle_o(idle), .carrier_o(carrier), .rx_clk_o(rx_clk), .rx_data_o(rx_data));

   // R3: carrier only rises after the squelch qualified a pulse
   assert_crs_qual_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carrier) |-> $past(qual));
endmodule

// File: tb/sim_rxdec_top.sv
module sim_rxdec_top;
   localparam int CLK_PERIOD = 10;
   localparam int OVS = 8, MP = 3, TB = 5, ST = 1;
   localparam int LIMIT = 20000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic loop_sel = 1'b0, line_rx = 1'b1, loop_tx = 1'b1;
   logic carrier, rx_data, rx_clk;

   rxdec_top #(.OVS(OVS), .MIN_PULSE(MP), .TAIL_BITS(TB), .IN_STAGES(ST)) u0 (
      .clk(clk), .rst_n(rst_n), .loop_sel(loop_sel), .line_rx(line_rx),
      .loop_tx(loop_tx), .carrier(carrier), .rx_data(rx_data), .rx_clk(rx_clk));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;
   int first_mid, last_mid, rise_cyc, fall_cyc, tail_rises, crs_rises;
   logic dec[$];
   logic pcrs = 1'b0, prxc = 1'b0;

   // behavioural reference
   int ms = 1, msp = 1, mlow = 0, mst = 0, mcnt = 0, mrxd = 0;
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         ms = 1; msp = 1; mlow = 0; mst = 0; mcnt = 0; mrxd = 0;
      end else begin
         bit ed, ql;
         ed = (ms != msp);
         ql = (mst == 0) && (ms == 0) && (mlow == MP - 1);
         if (mst == 0) begin
            if (ql) begin mst = 1; mcnt = MP; end
         end else if (mst == 1) begin
            if (mcnt == OVS/4) mrxd = ms;
            if (ed && mcnt >= OVS - OVS/4 && mcnt <= OVS + OVS/4) mcnt = 1;
            else if (mcnt == OVS + OVS/2 - 1) begin mst = 2; mcnt++; end
            else mcnt++;
         end else begin
            if (mcnt == OVS + OVS/2 + TB*OVS - 1) begin mst = 0; mcnt = 0; end
            else mcnt++;
         end
         mlow = ms ? 0 : (mlow < MP ? mlow + 1 : MP);
         msp = ms;
         ms = loop_sel ? loop_tx : line_rx;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // per-clock comparison and event monitor
   always @(negedge clk) begin
      chk("R3/R7 carrier", carrier, (mst == 1));
      chk("R8/R11 rx_clk", rx_clk, (mst != 0) && ((mcnt % OVS) >= OVS/2));
      chk("R5 rx_data", rx_data, mrxd);
      if (carrier && !pcrs) begin rise_cyc = cyc; crs_rises++; end
      if (!carrier && pcrs) fall_cyc = cyc;
      if (rx_clk && !prxc) begin
         if (carrier) dec.push_back(rx_data);
         else tail_rises++;
      end
      pcrs = carrier;
      prxc = rx_clk;
   end

   always @(posedge clk) if (cyc > LIMIT) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   task automatic put(input logic v, input logic on_loop);
      @(posedge clk); #1;
      if (on_loop) loop_tx = v; else line_rx = v;
   endtask

   task automatic hold(input logic v, input int n, input logic on_loop);
      for (int k = 0; k < n; k++) put(v, on_loop);
   endtask

   task automatic clear_mon();
      dec.delete();
      tail_rises = 0; crs_rises = 0; rise_cyc = -1; fall_cyc = -1;
   endtask

   // R4: every frame opens with a 0 cell (low byte 8'hAA)
   task automatic send_frame(input logic [23:0] w, input bit jit, input logic on_loop);
      for (int i = 0; i < 24; i++) begin
         int j = jit ? (i % 3) - 1 : 0;
         hold(!w[i], OVS/2 + j, on_loop);
         put(w[i], on_loop);
         last_mid = cyc;
         if (i == 0) first_mid = cyc;
         hold(w[i], OVS/2 - 1 - j, on_loop);
      end
   endtask

   task automatic frame_checks(input logic [23:0] w);
      chk("R3 rise delay", rise_cyc - first_mid, ST + MP);
      chk("R5 bit count", dec.size(), 24);
      for (int i = 1; i < 24 && i < dec.size(); i++)
         chk("R5/R6 decoded bit", dec[i], w[i]);
      chk("R7 fall delay", fall_cyc - last_mid, OVS + OVS/2 + ST);
      chk("R8 tail rises", tail_rises, TB);
      chk("R11 idle rx_clk", rx_clk, 0);
      chk("R11 idle carrier", carrier, 0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      chk("R1 carrier", carrier, 0);
      chk("R1 rx_clk", rx_clk, 0);
      chk("R1 rx_data", rx_data, 0);
      rst_n = 1'b1;
      hold(1, 20, 0);

      // R2: short low pulses are rejected
      clear_mon();
      hold(0, 1, 0); hold(1, 6, 0); hold(0, 2, 0); hold(1, 6, 0);
      hold(0, 1, 0); hold(1, 10, 0);
      chk("R2 glitch rises", crs_rises, 0);

      // clean frame
      clear_mon();
      send_frame(24'h5B3CAA, 0, 0);
      hold(1, 80, 0);
      frame_checks(24'h5B3CAA);

      // R6: mid-cell jitter of one sample
      clear_mon();
      send_frame(24'hC61DAA, 1, 0);
      hold(1, 80, 0);
      frame_checks(24'hC61DAA);

      // R9: activity during the tail
      clear_mon();
      send_frame(24'h7A0FAA, 0, 0);
      hold(1, 14, 0); hold(0, 6, 0); hold(1, 80, 0);
      chk("R9 tail restart", crs_rises, 1);
      chk("R9 tail rises", tail_rises, TB);

      // R10: loopback ignores the line
      loop_sel = 1'b1;
      hold(1, 4, 0);
      clear_mon();
      send_frame(24'h5B3CAA, 0, 0);
      hold(1, 80, 0);
      chk("R10 line ignored", crs_rises, 0);
      chk("R10 no clock", tail_rises + dec.size(), 0);
      clear_mon();
      send_frame(24'h39E4AA, 0, 1);
      hold(1, 80, 1);
      frame_checks(24'h39E4AA);
      chk("R10 loop frame", crs_rises, 1);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule